// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is a station-management master for the two-wire PHY management bus (MDC clock, MDIO data). It runs one Clause-22 register read or write at a time. A request carries a direction bit, a 5-bit PHY address, a 5-bit register address and 16 bits of write data. The request is taken only while the block is idle. The block then generates MDC from a divider tick and drives MDIO through separate output, output-enable and input signals, so the pad can sit outside the block.

Beyond shifting the frame, the master checks the shared line at three points. The line must read high at the end of the preamble. During a read, a PHY must pull the line low on the released turnaround clock. After the frame, one extra released clock is run and the line must read high again, showing that nothing still drives it. A failed check ends the transaction early. The error flag is set and `done_o` still pulses once, so the caller can retry or scan the next PHY address.

Every bit has two phases. MDC is low for one delay period while the new data bit is presented, then MDC is high for one delay period. A delay period lasts `div_i + 1` clock cycles. The input is sampled only in the last clock cycle of the high phase.

Top module: `mdio_master`

## Requirements
- R1: Each transaction begins with 32 driven ones. Every bit slot is a low phase followed by a high phase, each lasting `div_i + 1` clock cycles. MDC is low in the first phase and high in the second, and MDIO output and output-enable stay stable while MDC is high.
- R2: If MDIO reads 0 at the sampling point of the last preamble slot (slot 31), the transaction ends there with `err_o` = 1.
- R3: A read drives 14 bits after the preamble, MSB first: start `01`, opcode `10`, PHY address, register address (slots 32 to 45). It then releases MDIO (output-enable 0, output 0) for the rest of the frame.
- R4: For a read, slot 46 is a released turnaround slot. If MDIO reads 1 at its sampling point, the transaction ends there with `err_o` = 1.
- R5: For a read, slots 47 to 62 capture 16 data bits, MSB first, with MDIO released. After a successful read, `rdata_o` holds them. After a write or a failed transaction, `rdata_o` keeps its previous value.
- R6: The last slot is released: slot 63 for a read, slot 64 for a write. If MDIO reads 0 there, `err_o` = 1.
- R7: A write drives 32 bits after the preamble, MSB first: start `01`, opcode `01`, PHY address, register address, turnaround `10`, 16 data bits (slots 32 to 63).
- R8: MDIO input is sampled only in the last clock cycle of a slot's high phase. Its value in every other cycle has no effect.
- R9: A request (`req_valid_i` = 1) is accepted only while `busy_o` = 0. A request presented while busy has no effect on the frame in progress.
- R10: `done_o` pulses for exactly one cycle when a transaction ends, whether it succeeded or failed, and `busy_o` is 0 in that cycle. `err_o` changes only with `done_o` and is held until the next `done_o`. While idle, MDC is 0 and MDIO is released. After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| div_i | input | DIV_W | Delay period minus one, in clock cycles |
| req_valid_i | input | 1 | Request strobe, taken when idle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_phy_i | input | 5 | PHY address |
| req_reg_i | input | 5 | Register address |
| req_wdata_i | input | 16 | Write data |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| err_o | output | 1 | Last transaction failed a line check |
| rdata_o | output | 16 | Data from the last successful read |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO line value |

## Verification
The assertions check the handshake invariants on every cycle:
- `done_o` is a one-cycle pulse, and `busy_o` is 0 with it.
- Leaving busy always comes with done.
- Busy starts only from a request.
- MDC is low and MDIO is released while idle.
- The MDIO drive holds still while MDC is high.
- `err_o` moves only with done.

The frame content, the exact phase lengths, where each check falls and the captured read data depend on the PHY's answers. The bench shows these by comparing against its reference on every clock, over several dividers and faulty-line scenarios. One of those scenarios toggles the line away from the sampling cycle.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_LEN   = 32;
  localparam int PHY_W     = 5;
  localparam int REG_W     = 5;
  localparam int DATA_W    = 16;
  localparam int CMD_RD    = 4 + PHY_W + REG_W;
  localparam int FRAME_W   = PRE_LEN + CMD_RD + 2 + DATA_W;
  localparam int SLOT_W    = $clog2(FRAME_W + 2);
  localparam int TA_SLOT   = PRE_LEN + CMD_RD;
  localparam int RD_FIRST  = TA_SLOT + 1;
  localparam int RD_LAST   = TA_SLOT + DATA_W;
  localparam int RD_END    = RD_LAST + 1;
  localparam int WR_END    = FRAME_W;

  localparam logic [1:0] START_BITS = 2'b01;
  localparam logic [1:0] OP_READ    = 2'b10;
  localparam logic [1:0] OP_WRITE   = 2'b01;
  localparam logic [1:0] TA_WRITE   = 2'b10;

  typedef struct packed {
    logic [FRAME_W-1:0] bits;
    logic [SLOT_W-1:0]  drive_len;
    logic [SLOT_W-1:0]  last_slot;
  } frame_plan_t;
endpackage

// File: rtl/mdio_tick.sv
module mdio_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (!run || tick) begin
      cnt_q <= div;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_build.sv
module mdio_frame_build
  import mdio_pkg::*;
(
  input  logic              is_write,
  input  logic [PHY_W-1:0]  phy,
  input  logic [REG_W-1:0]  regad,
  input  logic [DATA_W-1:0] wdata,
  output frame_plan_t       plan
);
  localparam int RD_PAD = FRAME_W - PRE_LEN - CMD_RD;

  always_comb begin
    if (is_write) begin
      plan.bits      = {{PRE_LEN{1'b1}}, START_BITS, OP_WRITE, phy, regad, TA_WRITE, wdata};
      plan.drive_len = SLOT_W'(FRAME_W);
      plan.last_slot = SLOT_W'(WR_END);
    end else begin
      plan.bits      = {{PRE_LEN{1'b1}}, START_BITS, OP_READ, phy, regad, {RD_PAD{1'b0}}};
      plan.drive_len = SLOT_W'(PRE_LEN + CMD_RD);
      plan.last_slot = SLOT_W'(RD_END);
    end
  end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              start,
  input  logic              start_write,
  input  frame_plan_t       plan,
  input  logic              mdio_in,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rdata,
  output logic              mdc,
  output logic              mdo,
  output logic              oe
);
  localparam logic [SLOT_W-1:0] PRE_CHK = SLOT_W'(PRE_LEN - 1);
  localparam logic [SLOT_W-1:0] TA_CHK  = SLOT_W'(TA_SLOT);
  localparam logic [SLOT_W-1:0] D_LO    = SLOT_W'(RD_FIRST);
  localparam logic [SLOT_W-1:0] D_HI    = SLOT_W'(RD_LAST);

  logic               phase_q;
  logic               wr_q;
  logic [SLOT_W-1:0]  slot_q;
  logic [SLOT_W-1:0]  drive_len_q;
  logic [SLOT_W-1:0]  last_q;
  logic [FRAME_W-1:0] sh_q;
  logic [DATA_W-1:0]  cap_q;

  logic              fail;
  logic              in_data;
  logic [SLOT_W-1:0] slot_nx;
  logic              oe_nx;

  always_comb begin
    fail = 1'b0;
    if (slot_q == PRE_CHK && !mdio_in) fail = 1'b1;
    if (!wr_q && slot_q == TA_CHK && mdio_in) fail = 1'b1;
    if (slot_q == last_q && !mdio_in) fail = 1'b1;
    in_data = !wr_q && (slot_q >= D_LO) && (slot_q <= D_HI);
    slot_nx = slot_q + 1'b1;
    oe_nx   = slot_nx < drive_len_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      done        <= 1'b0;
      err         <= 1'b0;
      rdata       <= '0;
      mdc         <= 1'b0;
      mdo         <= 1'b0;
      oe          <= 1'b0;
      phase_q     <= 1'b0;
      wr_q        <= 1'b0;
      slot_q      <= '0;
      drive_len_q <= '0;
      last_q      <= '0;
      sh_q        <= '0;
      cap_q       <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy        <= 1'b1;
          phase_q     <= 1'b0;
          slot_q      <= '0;
          wr_q        <= start_write;
          drive_len_q <= plan.drive_len;
          last_q      <= plan.last_slot;
          sh_q        <= plan.bits;
          mdc         <= 1'b0;
          oe          <= 1'b1;
          mdo         <= plan.bits[FRAME_W-1];
        end
      end else if (tick) begin
        if (!phase_q) begin
          phase_q <= 1'b1;
          mdc     <= 1'b1;
        end else begin
          if (in_data) cap_q <= {cap_q[DATA_W-2:0], mdio_in};
          if (fail || slot_q == last_q) begin
            busy <= 1'b0;
            done <= 1'b1;
            err  <= fail;
            mdc  <= 1'b0;
            oe   <= 1'b0;
            mdo  <= 1'b0;
            if (!fail && !wr_q) rdata <= cap_q;
          end else begin
            slot_q  <= slot_nx;
            phase_q <= 1'b0;
            mdc     <= 1'b0;
            sh_q    <= {sh_q[FRAME_W-2:0], 1'b0};
            oe      <= oe_nx;
            mdo     <= oe_nx ? sh_q[FRAME_W-2] : 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_i,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic [4:0]       req_phy_i,
  input  logic [4:0]       req_reg_i,
  input  logic [15:0]      req_wdata_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [15:0]      rdata_o,
  output logic             mdc_o,
  output logic             mdio_o,
  output logic             mdio_oe_o,
  input  logic             mdio_i
);
  frame_plan_t plan;
  logic        tick;
  logic        accept;

  assign accept = req_valid_i && !busy_o;

  mdio_tick #(.DIV_W(DIV_W)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .run  (busy_o),
    .div  (div_i),
    .tick (tick)
  );

  mdio_frame_build u_build (
    .is_write (req_write_i),
    .phy      (req_phy_i),
    .regad    (req_reg_i),
    .wdata    (req_wdata_i),
    .plan     (plan)
  );

  mdio_frame_seq u_seq (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .start       (accept),
    .start_write (req_write_i),
    .plan        (plan),
    .mdio_in     (mdio_i),
    .busy        (busy_o),
    .done        (done_o),
    .err         (err_o),
    .rdata       (rdata_o),
    .mdc         (mdc_o),
    .mdo         (mdio_o),
    .oe          (mdio_oe_o)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic clk,
  input logic rst,
  input logic req_valid_i,
  input logic busy_o,
  input logic done_o,
  input logic err_o,
  input logic mdc_o,
  input logic mdio_o,
  input logic mdio_oe_o
);
  assert_idle_released_R10: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (!mdc_o && !mdio_oe_o));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  assert_end_has_done_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o);

  assert_err_with_done_R10: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(err_o));

  assert_start_from_req_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(req_valid_i));

  assert_stable_high_R1: assert property (@(posedge clk) disable iff (rst)
    (mdc_o && $past(mdc_o)) |-> ($stable(mdio_o) && $stable(mdio_oe_o)));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid_i (req_valid_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .mdc_o       (mdc_o),
  .mdio_o      (mdio_o),
  .mdio_oe_o   (mdio_oe_o)
);

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
module mdio_master_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  div = '0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [4:0]  req_phy = '0;
  logic [4:0]  req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic        busy, done, err, mdc, mdo, oe;
  logic [15:0] rdata;
  logic        stuck_low = 1'b0;
  logic        phy_line = 1'b1;
  logic        mdio_line;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [15:0] exp_rdata = '0;

  always #2 clk = ~clk;

  assign mdio_line = stuck_low ? 1'b0 : (oe ? mdo : phy_line);

  mdio_master #(.DIV_W(8)) u_dut (
    .clk(clk), .rst(rst), .div_i(div),
    .req_valid_i(req_valid), .req_write_i(req_write),
    .req_phy_i(req_phy), .req_reg_i(req_reg), .req_wdata_i(req_wdata),
    .busy_o(busy), .done_o(done), .err_o(err), .rdata_o(rdata),
    .mdc_o(mdc), .mdio_o(mdo), .mdio_oe_o(oe), .mdio_i(mdio_line)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // scen: 0 good, 1 line stuck low (R2), 2 no PHY answer (R4), 3 line held low at end (R6)
  task automatic run_txn(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                         input logic [15:0] wd, input logic [15:0] pdata,
                         input int scen, input int dv, input bit inject);
    bit   fbits[$];
    int   D, L, drive_len, endk;
    bit   exp_err;
    string etag;
    for (int i = 0; i < 32; i++) fbits.push_back(1'b1);
    fbits.push_back(1'b0); fbits.push_back(1'b1);
    if (wr) begin fbits.push_back(1'b0); fbits.push_back(1'b1); end
    else    begin fbits.push_back(1'b1); fbits.push_back(1'b0); end
    for (int i = 4; i >= 0; i--) fbits.push_back(phy[i]);
    for (int i = 4; i >= 0; i--) fbits.push_back(rg[i]);
    if (wr) begin
      fbits.push_back(1'b1); fbits.push_back(1'b0);
      for (int i = 15; i >= 0; i--) fbits.push_back(wd[i]);
    end
    drive_len = fbits.size();
    D = dv + 1;
    exp_err = 1'b0; etag = wr ? "R7" : "R5";
    L = wr ? 64 : 63;
    if (scen == 1) begin L = 31; exp_err = 1'b1; etag = "R2"; end
    else if (scen == 2 && !wr) begin L = 46; exp_err = 1'b1; etag = "R4"; end
    else if (scen == 3) begin exp_err = 1'b1; etag = "R6"; end
    endk = 2 * D * (L + 1);

    @(negedge clk);
    div = dv[7:0]; req_write = wr; req_phy = phy; req_reg = rg; req_wdata = wd;
    req_valid = 1'b1; stuck_low = (scen == 1);
    @(posedge clk);
    for (int k = 0; k <= endk + 1; k++) begin
      int  slot, pos;
      bit  hi, e_oe, e_mdo;
      string tg;
      @(negedge clk);
      req_valid = 1'b0;
      if (inject && k == 3) begin
        req_valid = 1'b1; req_write = ~wr; req_phy = ~phy; req_reg = ~rg; req_wdata = ~wd;
      end
      slot = k / (2 * D);
      pos  = k % (2 * D);
      hi   = pos >= D;
      // line as seen by the master while released (pull-up unless a PHY drives)
      phy_line = 1'b1;
      if (!wr && slot == 46) phy_line = (scen == 2);
      if (!wr && slot >= 47 && slot <= 62) begin
        bit b;
        b = pdata[15 - (slot - 47)];
        phy_line = (pos == 2 * D - 1) ? b : ~b; // R8: only the last high cycle counts
      end
      if ((!wr && slot == 63) || (wr && slot == 64)) phy_line = (scen != 3);
      if (k < endk) begin
        e_oe  = slot < drive_len;
        e_mdo = e_oe ? fbits[slot] : 1'b0;
        if (slot < 32) tg = "R1"; else if (wr) tg = "R7"; else tg = "R3";
        if (inject) tg = {tg, "/R9"};
        chk(tg, "mdc", mdc, hi);
        chk(tg, "mdio_oe", oe, e_oe);
        chk(tg, "mdio_out", mdo, e_mdo);
        chk("R10", "busy", busy, 1);
        chk("R10", "done", done, 0);
      end else if (k == endk) begin
        if (!exp_err && !wr) exp_rdata = pdata;
        chk("R10", "done at end", done, 1);
        chk("R10", "busy at end", busy, 0);
        chk("R10", "mdc idle", mdc, 0);
        chk("R10", "oe idle", oe, 0);
        chk(etag, "err", err, exp_err);
        chk(wr ? "R5" : "R8", "rdata", rdata, exp_rdata);
      end else begin
        chk("R10", "done pulse width", done, 0);
        chk("R10", "err held", err, exp_err);
      end
    end
    stuck_low = 1'b0;
    phy_line = 1'b1;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10", "reset busy", busy, 0);
    chk("R10", "reset done", done, 0);
    chk("R10", "reset err", err, 0);
    chk("R10", "reset rdata", rdata, 0);
    chk("R10", "reset mdc", mdc, 0);
    chk("R10", "reset oe", oe, 0);

    run_txn(1'b0, 5'h01, 5'h02, 16'h0000, 16'hA5C3, 0, 0, 1'b0);
    run_txn(1'b1, 5'h1F, 5'h04, 16'h01E1, 16'h0000, 0, 1, 1'b0);
    run_txn(1'b0, 5'h0A, 5'h11, 16'h0000, 16'h1234, 0, 3, 1'b1);
    run_txn(1'b0, 5'h03, 5'h00, 16'h0000, 16'hFFFF, 1, 1, 1'b0);
    run_txn(1'b0, 5'h04, 5'h01, 16'h0000, 16'h5555, 2, 1, 1'b0);
    run_txn(1'b1, 5'h05, 5'h00, 16'h8000, 16'h0000, 2, 0, 1'b1);
    run_txn(1'b0, 5'h06, 5'h1E, 16'h0000, 16'h0F0F, 3, 2, 1'b0);
    run_txn(1'b1, 5'h07, 5'h05, 16'hBEEF, 16'h0000, 3, 1, 1'b0);
    run_txn(1'b0, 5'h15, 5'h0A, 16'h0000, 16'h8001, 0, 2, 1'b0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule